// File: doc/BRIEF.md
# Programmable Trapezoidal Waveform Generator

This block produces a continuous piecewise-linear level on one registered output. On a cycle when the run input is seen high in the idle state, it captures five operands: a start level, a peak level, an end level and two dwell counts. It then plays out one round. The output sits at the start level for the first dwell count. It climbs by one per clock to the peak, descends by one per clock to the end level, and sits at the end level for the second dwell count. One recovery cycle follows, and the block returns to idle.

In idle the output keeps its last level, and a one-cycle done pulse marks the return. If run is still high in that idle cycle, the next round begins on the following edge, so a held run gives an unbroken train of trapezoids. Every phase ends on an equality compare, either between a dwell counter and its limit or between the working level and its target. A ramp that would have to wrap through 0 or the full-scale value is skipped, so the output never wraps. A phase code on the ports shows which phase is running.

Top module: `trap_wavegen`

## Requirements
- R1: A synchronous active-high reset forces phase code 0 (idle), output 0 and done low on the next edge, including in the middle of a round.
- R2: In idle with run low, the phase stays 0, the output keeps its level and done stays low.
- R3: All five operands are sampled on the edge where run is seen high in idle; input changes after that edge have no effect on the round in progress.
- R4: Starting the cycle after the sampling edge, the output equals the start level, with phase code 1, for T1 cycles.
- R5: When the peak is above the start level, phase code 2 shows the start level plus 1 first and then rises by exactly 1 per cycle, so that the peak is shown for exactly one cycle.
- R6: The falling phase (phase code 3) starts one below the level reached before it and drops by exactly 1 per cycle down to the end level, which is shown once in this phase.
- R7: If the peak is not above the start level, the rising phase is skipped and the fall starts from the start level.
- R8: If the end level is not below the level reached (the peak, or the start level when the rise is skipped), the falling phase is skipped and the output moves to the end level in one step.
- R9: The end level is held with phase code 4 for T2 cycles, then for one more cycle with phase code 5, then the block enters idle.
- R10: done is high for exactly the first idle cycle after a round, and the output still shows the end level.
- R11: If run is high in that idle cycle, the next round starts on the following edge (phase code 1, output at the new start level).
- R12: A dwell count of 0 behaves as a dwell of one cycle.
- R13: Ramps that reach the full-scale value or 0 do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start request, sampled in idle |
| lvl_start | input | W | Start level |
| lvl_end | input | W | End level |
| lvl_peak | input | W | Peak level |
| dwell_first | input | W | Hold count at the start level |
| dwell_last | input | W | Hold count at the end level |
| wave_out | output | W | Registered waveform level |
| done | output | 1 | One-cycle pulse when a round ends |
| phase | output | 3 | Current phase code |

## Verification
A nominal trapezoid is run with the start level below the end level and the end level below the peak, so both ramps have different lengths and both dwells are longer than one cycle. Zero dwell counts show whether a zero limit is turned into a one-cycle dwell instead of a wrap to 256 cycles. A peak below the start level and an end level above the peak take the skip paths one at a time. Equal start and peak levels with a higher end level take both skip paths together. Operands at 250, 255 and 0 drive the ramps to full scale and back to 0, which exposes any wrap. A held run checks that rounds follow each other, and a reset in the middle of a ramp checks the abort.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_HOLD_A  = 3'd1,
    PH_RISE    = 3'd2,
    PH_FALL    = 3'd3,
    PH_HOLD_B  = 3'd4,
    PH_RECOVER = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    LC_KEEP = 3'd0,
    LC_LOAD = 3'd1,
    LC_INC  = 3'd2,
    LC_DEC  = 3'd3,
    LC_SETB = 3'd4
  } lvl_cmd_e;

endpackage

// File: rtl/trap_dwell.sv
module trap_dwell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  // a zero limit is one cycle, like a limit of 1
  assign last    = (limit == '0) ? '0 : limit - 1'b1;
  assign expired = (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  a_r12_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    inc |-> (cnt_q < last));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     expired,
  input  logic     at_peak,
  input  logic     at_floor,
  input  logic     rise_ok,
  input  logic     fall_from_a,
  input  logic     fall_from_c,
  output phase_e   st,
  output lvl_cmd_e cmd,
  output logic     cnt_clr,
  output logic     cnt_inc,
  output logic     done
);
  phase_e nxt;

  always_comb begin
    nxt     = st;
    cmd     = LC_KEEP;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (st)
      PH_IDLE: if (run) begin
        nxt = PH_HOLD_A; cmd = LC_LOAD; cnt_clr = 1'b1;
      end
      PH_HOLD_A: begin
        if (expired) begin
          cnt_clr = 1'b1;
          if (rise_ok)          begin nxt = PH_RISE;   cmd = LC_INC;  end
          else if (fall_from_a) begin nxt = PH_FALL;   cmd = LC_DEC;  end
          else                  begin nxt = PH_HOLD_B; cmd = LC_SETB; end
        end else cnt_inc = 1'b1;
      end
      PH_RISE: begin
        if (at_peak) begin
          cnt_clr = 1'b1;
          if (fall_from_c) begin nxt = PH_FALL;   cmd = LC_DEC;  end
          else             begin nxt = PH_HOLD_B; cmd = LC_SETB; end
        end else cmd = LC_INC;
      end
      PH_FALL: begin
        if (at_floor) begin nxt = PH_HOLD_B; cnt_clr = 1'b1; end
        else cmd = LC_DEC;
      end
      PH_HOLD_B: begin
        if (expired) begin nxt = PH_RECOVER; cnt_clr = 1'b1; end
        else cnt_inc = 1'b1;
      end
      PH_RECOVER: nxt = PH_IDLE;
      default:    nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= PH_IDLE;
      done <= 1'b0;
    end else begin
      st   <= nxt;
      done <= (st == PH_RECOVER);
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (st == PH_IDLE && !done));
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_recover_one: assert property (@(posedge clk) disable iff (rst)
    (st == PH_RECOVER) |=> (st == PH_IDLE && done));
  a_r2_idle_wait: assert property (@(posedge clk) disable iff (rst)
    (st == PH_IDLE && !run) |=> (st == PH_IDLE));
endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  phase_e       st,
  input  lvl_cmd_e     cmd,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  input  logic [W-1:0] in_t1,
  input  logic [W-1:0] in_t2,
  output logic [W-1:0] level_q,
  output logic [W-1:0] dwell_lim,
  output logic         at_peak,
  output logic         at_floor,
  output logic         rise_ok,
  output logic         fall_from_a,
  output logic         fall_from_c
);
  logic [W-1:0] a_q, b_q, c_q, t1_q, t2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0; b_q <= '0; c_q <= '0; t1_q <= '0; t2_q <= '0;
    end else if (cmd == LC_LOAD) begin
      a_q <= in_a; b_q <= in_b; c_q <= in_c; t1_q <= in_t1; t2_q <= in_t2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else begin
      unique case (cmd)
        LC_LOAD: level_q <= in_a;
        LC_INC:  level_q <= level_q + 1'b1;
        LC_DEC:  level_q <= level_q - 1'b1;
        LC_SETB: level_q <= b_q;
        default: level_q <= level_q;
      endcase
    end
  end

  assign dwell_lim   = (st == PH_HOLD_B) ? t2_q : t1_q;
  assign at_peak     = (level_q == c_q);
  assign at_floor    = (level_q == b_q);
  assign rise_ok     = (c_q > a_q);
  assign fall_from_a = (b_q < a_q);
  assign fall_from_c = (b_q < c_q);

  a_r4_hold_a_level: assert property (@(posedge clk) disable iff (rst)
    (st == PH_HOLD_A) |-> (level_q == a_q));
  a_r5_rise_step: assert property (@(posedge clk) disable iff (rst)
    (st == PH_RISE && $past(st) == PH_RISE) |-> (level_q == W'($past(level_q) + 1'b1)));
  a_r6_fall_step: assert property (@(posedge clk) disable iff (rst)
    (st == PH_FALL && $past(st) == PH_FALL) |-> (level_q == W'($past(level_q) - 1'b1)));
  a_r13_rise_bounded: assert property (@(posedge clk) disable iff (rst)
    (st == PH_RISE) |-> (level_q > a_q && level_q <= c_q));
  a_r13_fall_bounded: assert property (@(posedge clk) disable iff (rst)
    (st == PH_FALL) |-> (level_q >= b_q));
  a_r9_hold_b_level: assert property (@(posedge clk) disable iff (rst)
    (st == PH_HOLD_B) |-> (level_q == b_q));
endmodule

// File: rtl/trap_wavegen.sv
module trap_wavegen
  import trap_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] lvl_start,
  input  logic [W-1:0] lvl_end,
  input  logic [W-1:0] lvl_peak,
  input  logic [W-1:0] dwell_first,
  input  logic [W-1:0] dwell_last,
  output logic [W-1:0] wave_out,
  output logic         done,
  output logic [2:0]   phase
);
  phase_e       st;
  lvl_cmd_e     cmd;
  logic         cnt_clr, cnt_inc, expired;
  logic         at_peak, at_floor, rise_ok, fall_from_a, fall_from_c;
  logic [W-1:0] dwell_lim;

  trap_ctrl u_ctrl (
    .clk, .rst, .run, .expired, .at_peak, .at_floor, .rise_ok,
    .fall_from_a, .fall_from_c, .st, .cmd, .cnt_clr, .cnt_inc, .done
  );

  trap_datapath #(.W(W)) u_dp (
    .clk, .rst, .st, .cmd,
    .in_a(lvl_start), .in_b(lvl_end), .in_c(lvl_peak),
    .in_t1(dwell_first), .in_t2(dwell_last),
    .level_q(wave_out), .dwell_lim, .at_peak, .at_floor,
    .rise_ok, .fall_from_a, .fall_from_c
  );

  trap_dwell #(.W(W)) u_dwell (
    .clk, .rst, .clr(cnt_clr), .inc(cnt_inc), .limit(dwell_lim), .expired
  );

  assign phase = st;
endmodule

// File: tb/sim_trap_wavegen.sv
`timescale 1ns/1ps
module sim_trap_wavegen;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic [W-1:0] la = '0, lb = '0, lc = '0, t1 = '0, t2 = '0;
  logic [W-1:0] wave_out;
  logic done;
  logic [2:0] phase;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trap_wavegen #(.W(W)) u0 (
    .clk, .rst, .run, .lvl_start(la), .lvl_end(lb), .lvl_peak(lc),
    .dwell_first(t1), .dwell_last(t2), .wave_out, .done, .phase
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one full round; checks every cycle's level and phase code
  task automatic run_round(input int a, input int b, input int c,
                           input int d1, input int d2, input bit keep);
    int q_out[$]; int q_ph[$]; string q_req[$];
    int top = a;
    int n1 = (d1 == 0) ? 1 : d1;
    int n2 = (d2 == 0) ? 1 : d2;
    for (int i = 0; i < n1; i++) begin q_out.push_back(a); q_ph.push_back(1); q_req.push_back("R4/R12"); end
    if (c > a) begin
      for (int v = a + 1; v <= c; v++) begin q_out.push_back(v); q_ph.push_back(2); q_req.push_back("R5/R13"); end
      top = c;
    end
    if (b < top) begin
      for (int v = top - 1; v >= b; v--) begin
        q_out.push_back(v); q_ph.push_back(3); q_req.push_back((c > a) ? "R6/R13" : "R7");
      end
    end
    for (int i = 0; i < n2; i++) begin q_out.push_back(b); q_ph.push_back(4); q_req.push_back((b >= top) ? "R8/R9" : "R9"); end
    q_out.push_back(b); q_ph.push_back(5); q_req.push_back("R9");

    @(negedge clk);
    la = W'(a); lb = W'(b); lc = W'(c); t1 = W'(d1); t2 = W'(d2); run = 1'b1;
    for (int i = 0; i < q_out.size(); i++) begin
      @(negedge clk);
      chk(wave_out == W'(q_out[i]), q_req[i], wave_out, q_out[i]);
      chk(phase == 3'(q_ph[i]), q_req[i], phase, q_ph[i]);
      if (i == 0 && !keep) begin
        run = 1'b0;  // R3: scramble operands after capture
        la = ~la; lb = ~lb; lc = ~lc; t1 = t1 + 8'd5; t2 = t2 + 8'd5;
      end
    end
    @(negedge clk);
    chk(done == 1'b1, "R10", done, 1);
    chk(wave_out == W'(b), "R10", wave_out, b);
    chk(phase == 3'd0, "R10", phase, 0);
    if (keep) begin
      @(negedge clk);
      chk(phase == 3'd1, "R11", phase, 1);
      chk(wave_out == W'(a), "R11", wave_out, a);
      chk(done == 1'b0, "R11", done, 0);
    end else begin
      @(negedge clk);
      chk(done == 1'b0, "R10", done, 0);
    end
  endtask

  task automatic idle_test(input int lvl);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(phase == 3'd0, "R2", phase, 0);
      chk(wave_out == W'(lvl), "R2", wave_out, lvl);
      chk(done == 1'b0, "R2", done, 0);
    end
  endtask

  task automatic reset_test();
    @(negedge clk); rst = 1'b1; run = 1'b0;
    @(negedge clk);
    chk(wave_out == '0, "R1", wave_out, 0);
    chk(phase == 3'd0, "R1", phase, 0);
    chk(done == 1'b0, "R1", done, 0);
    rst = 1'b0;
  endtask

  task automatic abort_test();
    @(negedge clk);
    la = 8'd10; lb = 8'd2; lc = 8'd40; t1 = 8'd1; t2 = 8'd1; run = 1'b1;
    @(negedge clk); run = 1'b0;
    repeat (5) @(negedge clk);
    chk(phase == 3'd2, "R5", phase, 2);
    reset_test();  // R1 mid-ramp
    idle_test(0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    reset_test();                      // R1
    run_round(3, 8, 12, 7, 3, 1'b0);   // nominal, R3 R4 R5 R6 R9 R10
    idle_test(8);                      // R2
    run_round(5, 2, 9, 0, 0, 1'b0);    // R12
    run_round(20, 5, 10, 2, 2, 1'b0);  // R7
    run_round(3, 9, 6, 2, 1, 1'b0);    // R8
    run_round(50, 60, 50, 1, 2, 1'b0); // R7 + R8
    run_round(250, 0, 255, 1, 1, 1'b0);// R13
    run_round(4, 1, 7, 2, 2, 1'b1);    // R11
    reset_test();
    abort_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule